// File: doc/BRIEF.md
# Serial-Programmed Synthesizer Divider Word Decoder

This block receives 24-bit programming words over a three-wire serial link made of a shift clock, a data line and a load strobe. All three pins are oversampled in the system clock domain. Bits enter a shift register most significant bit first on each rising edge of the shift clock. A rising edge on the load strobe sends the captured word to one of two decoded registers. The two lowest bits of the word select which one.

The feedback word carries a 13-bit feedback divide value and a charge-pump gain select. The reference word carries a 14-bit reference divide value, an anti-backlash width code, a lock-detect precision bit, a test-mode bit and a band-select clock divider code. Any word that would load a feedback divide value below 3, or a reference divide value of 0, is refused. The previous value is kept and an error flag goes high.

From the decoded values the block runs two dividers. The reference divider divides an incoming reference tick stream by the reference value. A band-select divider then divides the reference divider's output by 1, 2, 4 or 8. The serial link has no back-pressure: the sender owns its timing, and the block accepts every bit and every strobe it sees.

Top module: `pll_word_decoder`

## Requirements
- R1: Serial data is sampled on each rising edge of `ser_clk` and shifted in MSB first. A rising edge of `ser_le` applies the word to the decoded outputs, and the outputs never change at any other time.
- R2: Word bits [1:0] select the target. The value 2'b10 selects the feedback register and 2'b01 selects the reference register. Words ending in 2'b00 or 2'b11 leave every output unchanged.
- R3: In a feedback word, bits [20:8] hold the feedback divide value and bit 21 holds the charge-pump gain select. The gain select is 0 for current setting 1 and 1 for current setting 2.
- R4: A feedback divide value of 0, 1 or 2 is not loaded. Both feedback outputs keep their values and `fb_err` goes to 1. An accepted feedback word, including one with values 3 or 8191, clears `fb_err`.
- R5: In a reference word, bits [15:2] hold the reference divide value, [17:16] the anti-backlash code, bit 18 the lock-detect precision, bit 19 the test-mode bit and [21:20] the band-select code.
- R6: A reference divide value of 0 is not loaded. All reference outputs keep their values and `ref_err` goes to 1. An accepted reference word, including one with value 16383, clears `ref_err`.
- R7: After reset `fb_div` is 3, `ref_div` is 1, and every other decoded output, error flag and pulse is 0.
- R8: `ref_pulse` goes high for one cycle after every `ref_div`-th `ref_tick`, in the cycle that follows the completing tick.
- R9: `bsel_pulse` goes high for one cycle after every 1st, 2nd, 4th or 8th `ref_pulse`, for band-select codes 00, 01, 10 and 11, in the cycle that follows that `ref_pulse`.
- R10: An accepted reference word restarts the count of both dividers.
- R11: If more than 24 bits are shifted before a strobe, only the last 24 bits take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load strobe, applies the word on its rising edge |
| ref_tick | input | 1 | Reference tick, one cycle per reference period |
| fb_div | output | 13 | Feedback divide value |
| cp_gain | output | 1 | Charge-pump current setting select |
| ref_div | output | 14 | Reference divide value |
| ab_code | output | 2 | Anti-backlash width code |
| ld_prec | output | 1 | Lock-detect precision bit |
| test_mode | output | 1 | Test-mode bit |
| bsel_code | output | 2 | Band-select divider code |
| fb_err | output | 1 | Last feedback word was refused |
| ref_err | output | 1 | Last reference word was refused |
| ref_pulse | output | 1 | Reference divider output pulse |
| bsel_pulse | output | 1 | Band-select divider output pulse |

## Verification
The bench builds the block with the default field widths and two synchronizer stages. With these values, the extreme legal divide values (8191 and 16383) can be written directly, and the refusal boundaries at 2/3 and 0/1 can be tested with real words. Divider behaviour is checked with small reference values and all four band-select codes, and the restart is checked by a rewrite in the middle of a count. Oversized frames and words with unused control codes show whether anything other than the last 24 bits leaks through.

// File: rtl/pwd_pkg.sv
package pwd_pkg;
  localparam int WORD_W  = 24;
  localparam int FB_W    = 13;
  localparam int REF_W   = 14;
  localparam int FB_LSB  = 8;
  localparam int GAIN_B  = 21;
  localparam int REF_LSB = 2;
  localparam int AB_LSB  = 16;
  localparam int LDP_B   = 18;
  localparam int TM_B    = 19;
  localparam int BS_LSB  = 20;
  localparam int FB_MIN  = 3;
  localparam int BDIV_W  = 4;

  localparam logic [1:0] SEL_FB  = 2'b10;
  localparam logic [1:0] SEL_REF = 2'b01;

  typedef struct packed {
    logic [FB_W-1:0] div;
    logic            gain;
  } fb_cfg_t;

  typedef struct packed {
    logic [REF_W-1:0] div;
    logic [1:0]       ab;
    logic             ldp;
    logic             tm;
    logic [1:0]       bs;
  } ref_cfg_t;

  function automatic logic [BDIV_W-1:0] band_divisor(input logic [1:0] code);
    return BDIV_W'(1) << code;
  endfunction
endpackage

// File: rtl/pwd_serial_in.sv
module pwd_serial_in #(
  parameter int SYNC_STAGES = 2,
  parameter int WORD_W      = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_le,
  output logic [WORD_W-1:0] word,
  output logic              load_stb
);
  localparam int LANES = 3;

  logic [SYNC_STAGES-1:0][LANES-1:0] pipe;
  logic [LANES-1:0] synced;
  logic sclk_d, le_d;
  logic sclk_rise;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {ser_clk, ser_data, ser_le};
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[SYNC_STAGES-2:0], {ser_clk, ser_data, ser_le}};
      end
    end
  endgenerate

  assign synced    = pipe[SYNC_STAGES-1];
  assign sclk_rise = synced[2] & ~sclk_d;
  assign load_stb  = synced[0] & ~le_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      le_d   <= 1'b0;
      word   <= '0;
    end else begin
      sclk_d <= synced[2];
      le_d   <= synced[0];
      if (sclk_rise) word <= {word[WORD_W-2:0], synced[1]};
    end
  end
endmodule

// File: rtl/pwd_latch_bank.sv
module pwd_latch_bank
  import pwd_pkg::*;
#(
  parameter logic [FB_W-1:0]  FB_RST  = FB_W'(3),
  parameter logic [REF_W-1:0] REF_RST = REF_W'(1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word,
  input  logic              load_stb,
  output fb_cfg_t           fb_cfg,
  output ref_cfg_t          ref_cfg,
  output logic              fb_err,
  output logic              ref_err,
  output logic              restart
);
  fb_cfg_t  fb_new;
  ref_cfg_t ref_new;
  logic     is_fb, is_ref, fb_ok, ref_ok;

  always_comb begin
    fb_new.div  = word[FB_LSB +: FB_W];
    fb_new.gain = word[GAIN_B];
    ref_new.div = word[REF_LSB +: REF_W];
    ref_new.ab  = word[AB_LSB +: 2];
    ref_new.ldp = word[LDP_B];
    ref_new.tm  = word[TM_B];
    ref_new.bs  = word[BS_LSB +: 2];
    is_fb  = load_stb && (word[1:0] == SEL_FB);
    is_ref = load_stb && (word[1:0] == SEL_REF);
    fb_ok  = fb_new.div >= FB_W'(FB_MIN);
    ref_ok = ref_new.div != '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fb_cfg  <= '{div: FB_RST, gain: 1'b0};
      ref_cfg <= '{div: REF_RST, ab: 2'b00, ldp: 1'b0, tm: 1'b0, bs: 2'b00};
      fb_err  <= 1'b0;
      ref_err <= 1'b0;
      restart <= 1'b0;
    end else begin
      restart <= 1'b0;
      if (is_fb) begin
        fb_err <= !fb_ok;
        if (fb_ok) fb_cfg <= fb_new;
      end
      if (is_ref) begin
        ref_err <= !ref_ok;
        if (ref_ok) begin
          ref_cfg <= ref_new;
          restart <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pwd_tick_div.sv
module pwd_tick_div #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         tick,
  input  logic [W-1:0] divisor,
  output logic         pulse
);
  logic [W-1:0] cnt;
  logic [W:0]   next_cnt;

  assign next_cnt = {1'b0, cnt} + (W+1)'(1);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (tick) begin
        if (next_cnt >= {1'b0, divisor}) begin
          cnt   <= '0;
          pulse <= 1'b1;
        end else begin
          cnt <= next_cnt[W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/pll_word_decoder.sv
module pll_word_decoder
  import pwd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             ser_data,
  input  logic             ser_le,
  input  logic             ref_tick,
  output logic [FB_W-1:0]  fb_div,
  output logic             cp_gain,
  output logic [REF_W-1:0] ref_div,
  output logic [1:0]       ab_code,
  output logic             ld_prec,
  output logic             test_mode,
  output logic [1:0]       bsel_code,
  output logic             fb_err,
  output logic             ref_err,
  output logic             ref_pulse,
  output logic             bsel_pulse
);
  logic [WORD_W-1:0] word;
  logic              load_stb;
  logic              restart;
  fb_cfg_t           fb_cfg;
  ref_cfg_t          ref_cfg;

  pwd_serial_in #(.SYNC_STAGES(SYNC_STAGES), .WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_le(ser_le), .word(word), .load_stb(load_stb)
  );

  pwd_latch_bank u_bank (
    .clk(clk), .rst_n(rst_n), .word(word), .load_stb(load_stb),
    .fb_cfg(fb_cfg), .ref_cfg(ref_cfg), .fb_err(fb_err),
    .ref_err(ref_err), .restart(restart)
  );

  pwd_tick_div #(.W(REF_W)) u_refdiv (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(ref_tick),
    .divisor(ref_cfg.div), .pulse(ref_pulse)
  );

  pwd_tick_div #(.W(BDIV_W)) u_bseldiv (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(ref_pulse),
    .divisor(band_divisor(ref_cfg.bs)), .pulse(bsel_pulse)
  );

  assign fb_div    = fb_cfg.div;
  assign cp_gain   = fb_cfg.gain;
  assign ref_div   = ref_cfg.div;
  assign ab_code   = ref_cfg.ab;
  assign ld_prec   = ref_cfg.ldp;
  assign test_mode = ref_cfg.tm;
  assign bsel_code = ref_cfg.bs;
endmodule

// File: rtl/pll_word_decoder_chk.sv
module pll_word_decoder_chk
  import pwd_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             ref_tick,
  input logic [FB_W-1:0]  fb_div,
  input logic [REF_W-1:0] ref_div,
  input logic             fb_err,
  input logic             ref_err,
  input logic             ref_pulse,
  input logic             bsel_pulse
);
  assert_fb_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fb_div >= FB_W'(FB_MIN));

  assert_ref_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ref_div != '0);

  assert_fb_hold_on_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fb_err) |-> $stable(fb_div));

  assert_ref_hold_on_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_err) |-> $stable(ref_div));

  assert_fb_change_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fb_div) |-> !fb_err);

  assert_ref_pulse_follows_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pulse |-> $past(ref_tick));

  assert_bsel_follows_ref_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bsel_pulse |-> $past(ref_pulse));

  assert_ref_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pulse && ref_div != REF_W'(1) |=> !ref_pulse);
endmodule

bind pll_word_decoder pll_word_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .fb_div(fb_div),
  .ref_div(ref_div), .fb_err(fb_err), .ref_err(ref_err),
  .ref_pulse(ref_pulse), .bsel_pulse(bsel_pulse)
);

// File: tb/pll_word_decoder_test.sv
module pll_word_decoder_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0, ref_tick = 1'b0;
  logic [12:0] fb_div;
  logic [13:0] ref_div;
  logic cp_gain, ld_prec, test_mode, fb_err, ref_err, ref_pulse, bsel_pulse;
  logic [1:0] ab_code, bsel_code;

  int total = 0;
  int bad = 0;
  int ref_seen = 0;
  int bsel_seen = 0;

  typedef struct {
    logic [12:0] fb;
    logic        g;
    logic [13:0] r;
    logic [1:0]  ab;
    logic        ldp;
    logic        tm;
    logic [1:0]  bs;
    logic        fe;
    logic        re;
    string       tag;
  } exp_t;

  exp_t model;
  exp_t exp_q[$];
  event chk_ev;

  always #10 clk = ~clk;

  pll_word_decoder #(.SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_le(ser_le), .ref_tick(ref_tick), .fb_div(fb_div), .cp_gain(cp_gain),
    .ref_div(ref_div), .ab_code(ab_code), .ld_prec(ld_prec),
    .test_mode(test_mode), .bsel_code(bsel_code), .fb_err(fb_err),
    .ref_err(ref_err), .ref_pulse(ref_pulse), .bsel_pulse(bsel_pulse)
  );

  always @(posedge clk) begin
    if (ref_pulse) ref_seen++;
    if (bsel_pulse) bsel_seen++;
  end

  task automatic check(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        check({e.tag, " fb_div"},    fb_div,    e.fb);
        check({e.tag, " cp_gain"},   cp_gain,   e.g);
        check({e.tag, " ref_div"},   ref_div,   e.r);
        check({e.tag, " ab_code"},   ab_code,   e.ab);
        check({e.tag, " ld_prec"},   ld_prec,   e.ldp);
        check({e.tag, " test_mode"}, test_mode, e.tm);
        check({e.tag, " bsel_code"}, bsel_code, e.bs);
        check({e.tag, " fb_err"},    fb_err,    e.fe);
        check({e.tag, " ref_err"},   ref_err,   e.re);
      end
    end
  end

  task automatic expect_now(input string tag);
    exp_t e;
    e = model;
    e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    -> chk_ev;
    @(negedge clk);
  endtask

  task automatic send_bits(input logic [31:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk);
      ser_data = bits[i];
      ser_clk  = 1'b0;
      repeat (3) @(negedge clk);
      ser_clk = 1'b1;
      repeat (3) @(negedge clk);
      ser_clk = 1'b0;
    end
    repeat (3) @(negedge clk);
    ser_le = 1'b1;
    repeat (4) @(negedge clk);
    ser_le = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic write_fb(input int b, input bit g, input string tag);
    send_bits({8'h00, 2'b00, g, 13'(b), 6'b0, 2'b10}, 24);
    if (b >= 3) begin model.fb = 13'(b); model.g = g; model.fe = 1'b0; end
    else model.fe = 1'b1;
    expect_now(tag);
  endtask

  task automatic write_ref(input int r, input logic [1:0] ab, input bit ldp,
                           input bit tm, input logic [1:0] bs, input string tag);
    send_bits({8'h00, 2'b00, bs, tm, ldp, ab, 14'(r), 2'b01}, 24);
    if (r != 0) begin
      model.r = 14'(r); model.ab = ab; model.ldp = ldp; model.tm = tm;
      model.bs = bs; model.re = 1'b0;
    end else model.re = 1'b1;
    expect_now(tag);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ref_tick = 1'b1;
      @(negedge clk); ref_tick = 1'b0;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic div_run(input int n, input int exp_ref, input int exp_bsel, input string tag);
    int r0, b0;
    r0 = ref_seen; b0 = bsel_seen;
    ticks(n);
    check({tag, " R8 ref pulses"}, ref_seen - r0, exp_ref);
    check({tag, " R9 bsel pulses"}, bsel_seen - b0, exp_bsel);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : driver
    model = '{fb: 13'd3, g: 1'b0, r: 14'd1, ab: 2'b00, ldp: 1'b0, tm: 1'b0,
              bs: 2'b00, fe: 1'b0, re: 1'b0, tag: ""};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    expect_now("R7 reset");
    check("R7 ref_pulse idle", ref_pulse, 0);
    check("R7 bsel_pulse idle", bsel_pulse, 0);

    write_fb(1234, 1'b1, "R1 R3 fb word");
    write_fb(2, 1'b0, "R4 fb 2 refused");
    write_fb(0, 1'b1, "R4 fb 0 refused");
    write_fb(3, 1'b0, "R4 fb 3 accepted");
    write_fb(8191, 1'b1, "R4 fb 8191 accepted");
    write_ref(5, 2'b01, 1'b1, 1'b0, 2'b01, "R5 ref word");
    write_ref(0, 2'b10, 1'b0, 1'b1, 2'b11, "R6 ref 0 refused");
    write_ref(16383, 2'b11, 1'b0, 1'b1, 2'b10, "R6 ref 16383 accepted");

    // R2: unused control codes leave everything unchanged
    send_bits({8'h00, 24'hFFFFFC}, 24);
    expect_now("R2 code 00 ignored");
    send_bits({8'h00, 24'h123457}, 24);
    expect_now("R2 code 11 ignored");

    // R11: 28 bits, leading nibble is garbage
    send_bits({4'h0, 4'hD, 2'b00, 1'b0, 13'd777, 6'b0, 2'b10}, 28);
    model.fb = 13'd777; model.g = 1'b0; model.fe = 1'b0;
    expect_now("R11 oversized frame");

    // R1: shifting without a strobe changes nothing
    fork
      begin
        for (int i = 0; i < 24; i++) begin
          @(negedge clk); ser_data = i[0];
          repeat (3) @(negedge clk); ser_clk = 1'b1;
          repeat (3) @(negedge clk); ser_clk = 1'b0;
        end
      end
    join
    repeat (6) @(negedge clk);
    expect_now("R1 no strobe no change");

    write_ref(5, 2'b00, 1'b0, 1'b0, 2'b01, "R5 div setup a");
    div_run(40, 8, 4, "R8 R9 ref5 bs01");
    write_ref(1, 2'b00, 1'b0, 1'b0, 2'b11, "R5 div setup b");
    div_run(16, 16, 2, "R8 R9 ref1 bs11");
    write_ref(3, 2'b00, 1'b0, 1'b0, 2'b10, "R5 div setup c");
    div_run(24, 8, 2, "R8 R9 ref3 bs10");
    write_ref(2, 2'b00, 1'b0, 1'b0, 2'b00, "R5 div setup d");
    div_run(6, 3, 3, "R8 R9 ref2 bs00");

    // R10: restart mid-count
    write_ref(3, 2'b00, 1'b0, 1'b0, 2'b00, "R10 setup");
    div_run(2, 0, 0, "R10 partial count");
    write_ref(3, 2'b00, 1'b0, 1'b0, 2'b00, "R10 rewrite");
    div_run(2, 0, 0, "R10 after restart");
    div_run(1, 1, 1, "R10 third tick");

    // R4 error flag cleared by a following good word
    write_fb(1, 1'b0, "R4 fb 1 refused");
    write_fb(100, 1'b0, "R4 fb error cleared");

    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule